// File: doc/BRIEF.md
# Banked Expansion Memory Window Controller

This block sits on an expansion memory card attached to the parallel expansion bus of an 8-bit home computer. It watches the CPU address, data, read/write strobe and the phase-2 bus clock, all sampled by a fast card clock. It holds one 8-bit bank number and uses it to steer the 16 KB CPU range $4000-$7FFF onto a 4 MB external SRAM built from four 1 MB chips. The card takes the place of the computer's own RAM in that range rather than adding to it.

Three write paths can load the bank number:

- A native bank register on the card's own device page. It honours the card-select line.
- A write-only mirror at $CFFF. This address overlays system ROM, so the card never drives data for it.
- A mirror of the system port register. Only four of its bits are used.

The two mirrors react to writes whether or not the card is selected. Two jumpers pick one of four memory maps. In one map all 4 MB belong to the native register. In the other three maps the native register gets the lower 3 MB and one compatibility scheme gets the top 1 MB.

Top module: `xmw_bank_ctl`

## Requirements
- R1: While rst_n is low at a clock edge, the bank number clears to 0, so the next window access uses SRAM address bits [21:14] = 0.
- R2: When card_sel is high, bus_phi2 is high and bus_addr[15:14] = 2'b01, the outputs are set as follows. sram_addr is {bank, bus_addr[13:0]}. sram_chip_sel is one-hot with bit index bank[7:6]. In every other case sram_chip_sel is 0.
- R3: data_drive_en is high only for a window read (bus_rw = 1) with card_sel and bus_phi2 high. It is never high for reads of $CFFF, of the port mirror address $D301, or of any address outside the window.
- R4: sram_we is high only for a window write (bus_rw = 0) with card_sel and bus_phi2 high.
- R5: In map_mode 0, a selected write of value v to $D1FE loads the bank number with all 8 bits of v.
- R6: In map_mode 1, 2 or 3, a selected write to $D1FE loads v. If v[7:6] = 2'b11, the top two bits are stored as 2'b10 instead, so the native register never reaches the top 1 MB.
- R7: In map_mode 1, a write of v to $CFFF loads the bank number with {2'b11, v[5:0]}, whatever the state of card_sel. In any other mode such a write has no effect.
- R8: In map_mode 2, a write of v to $D301 loads {4'b1100, v[6], v[5], v[3], v[2]}. In map_mode 3 it loads {4'b1100, v[3], v[2], v[6], v[5]}. Both ignore card_sel and the other data bits. In map_mode 0 and 1 such a write has no effect.
- R9: A write to $D1FE with card_sel low leaves the bank number unchanged. So does a read of any register address.
- R10: The bank number changes only at the falling edge of bus_phi2. The edge is detected one card clock after bus_phi2 is sampled low, using the address, data and strobe present at that clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Card clock, faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| map_mode | input | 2 | Jumper map: 0 all native, 1 ROM mirror, 2 port scheme A, 3 port scheme B |
| bus_phi2 | input | 1 | Bus phase-2 clock |
| bus_rw | input | 1 | 1 = CPU read, 0 = CPU write |
| card_sel | input | 1 | Card selected on the expansion bus (active high) |
| bus_addr | input | 16 | CPU address |
| bus_data | input | 8 | CPU write data |
| sram_addr | output | 22 | SRAM address: bank and window offset |
| sram_chip_sel | output | 4 | One-hot select of the 1 MB SRAM chips |
| sram_we | output | 1 | SRAM write strobe |
| data_drive_en | output | 1 | Card drives the CPU data bus |

## Verification
The bank logic is tried in every jumper map with both directed and random patterns:

- The directed values put ones into bits the schemes discard (bits 0, 1, 4 and 7 for the port mirror, bits 7:6 for the ROM mirror). This separates a correct bit pick from a plain copy of the data.
- Native values with both top bits set tell the split-map fold apart from a full 8-bit load.
- Random mixes cover register writes with card_sel low, register reads, and the same write repeated in a mode where it must be ignored. These show whether each decode honours, or correctly ignores, the select line and the mode.
- Each register write is followed by a window read whose SRAM address reveals the stored bank.
- One directed cycle changes the address while bus_phi2 stays high. It shows that capture happens at the phase-2 fall and not at the rise.

// File: rtl/xmw_pkg.sv
// Shared types and constants for the banked expansion memory window controller.
// Assumes an 8-bit bank number and a 16 KB CPU window.
package xmw_pkg;
    typedef enum logic [1:0] {
        MAP_NATIVE = 2'd0,
        MAP_MIRROR = 2'd1,
        MAP_PORT_A = 2'd2,
        MAP_PORT_B = 2'd3
    } map_e;

    localparam int BANK_W = 8;
    localparam int OFS_W  = 14;
    localparam int CHIP_W = 2;
endpackage

// File: rtl/xmw_edge_detect.sv
// Detects the falling edge of the bus phase-2 clock in the card clock domain.
// Assumes bus_phi2 is already stable relative to clk (bus much slower).
module xmw_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic phi2,
    output logic phi2_fall
);
    logic phi2_q;

    // Remember last sampled phase-2 level
    always_ff @(posedge clk) begin
        if (!rst_n) phi2_q <= 1'b0;
        else        phi2_q <= phi2;
    end

    assign phi2_fall = phi2_q & ~phi2;
endmodule

// File: rtl/xmw_bank_decode.sv
// Decodes the three bank-load paths and forms the value to store.
// Assumes register addresses are distinct, so at most one path fires.
module xmw_bank_decode
    import xmw_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter int          DATA_W      = BANK_W,
    parameter logic [15:0] NATIVE_ADDR = 16'hD1FE,
    parameter logic [15:0] MIRROR_ADDR = 16'hCFFF,
    parameter logic [15:0] PORT_ADDR   = 16'hD301
) (
    input  logic              phi2_fall,
    input  logic              rw,
    input  logic              sel,
    input  map_e              mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              load_en,
    output logic [BANK_W-1:0] load_val
);
    localparam int LOW_W = BANK_W - 2;
    localparam int PAD_W = BANK_W - 6;

    logic             wr_edge;
    logic             nat_hit, mir_hit, port_hit;
    logic [BANK_W-1:0] nat_val, mir_val, port_val;
    logic [3:0]        port_idx;

    assign wr_edge  = phi2_fall & ~rw;
    assign nat_hit  = wr_edge & sel & (addr == NATIVE_ADDR);
    assign mir_hit  = wr_edge & (addr == MIRROR_ADDR) & (mode == MAP_MIRROR);
    assign port_hit = wr_edge & (addr == PORT_ADDR) &
                      ((mode == MAP_PORT_A) || (mode == MAP_PORT_B));

    // Native value, folded out of the reserved top region in split maps
    always_comb begin
        nat_val = data[BANK_W-1:0];
        if (mode != MAP_NATIVE && data[BANK_W-1 -: 2] == 2'b11)
            nat_val[BANK_W-1 -: 2] = 2'b10;
    end

    // Port mirror bit pick differs between the two port schemes
    always_comb begin
        if (mode == MAP_PORT_B) port_idx = {data[3], data[2], data[6], data[5]};
        else                    port_idx = {data[6], data[5], data[3], data[2]};
    end

    assign mir_val  = {2'b11, data[LOW_W-1:0]};
    assign port_val = {2'b11, {PAD_W{1'b0}}, port_idx};

    // Select the source that fired
    always_comb begin
        load_en  = nat_hit | mir_hit | port_hit;
        load_val = nat_val;
        if (mir_hit)  load_val = mir_val;
        if (port_hit) load_val = port_val;
    end
endmodule

// File: rtl/xmw_bank_reg.sv
// Holds the active bank number; cleared by synchronous reset.
module xmw_bank_reg
    import xmw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [BANK_W-1:0] load_val,
    output logic [BANK_W-1:0] bank_q
);
    // Store a new bank when a decode path fires
    always_ff @(posedge clk) begin
        if (!rst_n)       bank_q <= '0;
        else if (load_en) bank_q <= load_val;
    end
endmodule

// File: rtl/xmw_window_map.sv
// Maps the 16 KB CPU window onto the SRAM and produces the chip selects,
// write strobe and data-bus drive enable. Purely combinational.
module xmw_window_map
    import xmw_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] WIN_BASE = 16'h4000
) (
    input  logic                     phi2,
    input  logic                     rw,
    input  logic                     sel,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [BANK_W-1:0]        bank,
    output logic [BANK_W+OFS_W-1:0]  sram_addr,
    output logic [(1<<CHIP_W)-1:0]   chip_sel,
    output logic                     sram_we,
    output logic                     drive_en
);
    localparam int TAG_W  = ADDR_W - OFS_W;
    localparam int N_CHIP = 1 << CHIP_W;
    localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:OFS_W];

    logic active;

    assign active    = sel & phi2 & (addr[ADDR_W-1:OFS_W] == WIN_TAG);
    assign sram_addr = {bank, addr[OFS_W-1:0]};
    assign sram_we   = active & ~rw;
    assign drive_en  = active & rw;

    for (genvar g = 0; g < N_CHIP; g++) begin : g_chip
        assign chip_sel[g] = active & (bank[BANK_W-1 -: CHIP_W] == g[CHIP_W-1:0]);
    end
endmodule

// File: rtl/xmw_bank_ctl.sv
// Top: bank-select and address-translation controller for an expansion
// memory card. Assumes bus inputs are slow relative to clk.
module xmw_bank_ctl
    import xmw_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              map_mode,
    input  logic                    bus_phi2,
    input  logic                    bus_rw,
    input  logic                    card_sel,
    input  logic [15:0]             bus_addr,
    input  logic [7:0]              bus_data,
    output logic [21:0]             sram_addr,
    output logic [3:0]              sram_chip_sel,
    output logic                    sram_we,
    output logic                    data_drive_en
);
    logic              phi2_fall;
    logic              load_en;
    logic [BANK_W-1:0] load_val;
    logic [BANK_W-1:0] bank_q;
    map_e              mode;

    assign mode = map_e'(map_mode);

    xmw_edge_detect u_edge (
        .clk(clk), .rst_n(rst_n), .phi2(bus_phi2), .phi2_fall(phi2_fall)
    );

    xmw_bank_decode u_dec (
        .phi2_fall(phi2_fall), .rw(bus_rw), .sel(card_sel), .mode(mode),
        .addr(bus_addr), .data(bus_data),
        .load_en(load_en), .load_val(load_val)
    );

    xmw_bank_reg u_reg (
        .clk(clk), .rst_n(rst_n), .load_en(load_en),
        .load_val(load_val), .bank_q(bank_q)
    );

    xmw_window_map u_map (
        .phi2(bus_phi2), .rw(bus_rw), .sel(card_sel), .addr(bus_addr),
        .bank(bank_q), .sram_addr(sram_addr), .chip_sel(sram_chip_sel),
        .sram_we(sram_we), .drive_en(data_drive_en)
    );
endmodule

// File: rtl/xmw_bank_chk.sv
// Property checker for xmw_bank_ctl, attached by bind.
module xmw_bank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  map_mode,
    input logic        bus_phi2,
    input logic        bus_rw,
    input logic        card_sel,
    input logic [15:0] bus_addr,
    input logic [21:0] sram_addr,
    input logic [3:0]  sram_chip_sel,
    input logic        sram_we,
    input logic        data_drive_en,
    input logic [7:0]  bank_q
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> bank_q == 8'h00);

    // R10
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(bus_phi2) |=> $stable(bank_q));

    // R3
    no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_drive_en |-> (bus_rw && bus_phi2 && card_sel && bus_addr[15:14] == 2'b01));

    // R4
    we_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we |-> (!bus_rw && bus_phi2 && card_sel && bus_addr[15:14] == 2'b01));

    // R2
    chip_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sram_chip_sel));

    // R2
    chip_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_chip_sel != 4'b0) |-> sram_chip_sel[sram_addr[21:20]]);

    // R6
    fold_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (map_mode != 2'd0 && $fell(bus_phi2) && !bus_rw && card_sel && bus_addr == 16'hD1FE)
        |=> bank_q[7:6] != 2'b11);

    // R9
    unsel_native_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_phi2) && !card_sel && bus_addr == 16'hD1FE) |=> $stable(bank_q));
endmodule

bind xmw_bank_ctl xmw_bank_chk chk_i (
    .clk(clk), .rst_n(rst_n), .map_mode(map_mode), .bus_phi2(bus_phi2),
    .bus_rw(bus_rw), .card_sel(card_sel), .bus_addr(bus_addr),
    .sram_addr(sram_addr), .sram_chip_sel(sram_chip_sel),
    .sram_we(sram_we), .data_drive_en(data_drive_en), .bank_q(bank_q)
);

// File: tb/xmw_bank_ctl_tb_top.sv
// Self-checking bench: directed corner cases plus seeded random bus traffic.
module xmw_bank_ctl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  map_mode = 2'd0;
    logic        bus_phi2 = 1'b0;
    logic        bus_rw = 1'b1;
    logic        card_sel = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic [7:0]  bus_data = 8'h00;
    logic [21:0] sram_addr;
    logic [3:0]  sram_chip_sel;
    logic        sram_we;
    logic        data_drive_en;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model_bank = 8'h00;

    always #2.5 clk = ~clk;

    xmw_bank_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .map_mode(map_mode), .bus_phi2(bus_phi2),
        .bus_rw(bus_rw), .card_sel(card_sel), .bus_addr(bus_addr),
        .bus_data(bus_data), .sram_addr(sram_addr),
        .sram_chip_sel(sram_chip_sel), .sram_we(sram_we),
        .data_drive_en(data_drive_en)
    );

    // Expected bank after one bus cycle, from the requirements
    function automatic logic [7:0] next_bank(input logic [1:0] m, input logic [7:0] b,
                                             input logic [15:0] a, input logic [7:0] d,
                                             input logic rw, input logic sel);
        logic [7:0] r;
        r = b;
        if (!rw) begin
            if (a == 16'hD1FE && sel) begin
                r = d;
                if (m != 2'd0 && d[7:6] == 2'b11) r[7:6] = 2'b10;
            end else if (a == 16'hCFFF && m == 2'd1) begin
                r = {2'b11, d[5:0]};
            end else if (a == 16'hD301 && m == 2'd2) begin
                r = {4'b1100, d[6], d[5], d[3], d[2]};
            end else if (a == 16'hD301 && m == 2'd3) begin
                r = {4'b1100, d[3], d[2], d[6], d[5]};
            end
        end
        return r;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One bus cycle; outputs checked while phase 2 is high
    task automatic bus_op(input logic [15:0] a, input logic [7:0] d, input logic rw,
                          input logic sel, input string tag);
        logic win;
        @(negedge clk);
        bus_addr = a; bus_data = d; bus_rw = rw; card_sel = sel; bus_phi2 = 1'b0;
        @(negedge clk);
        bus_phi2 = 1'b1;
        repeat (2) @(negedge clk);
        win = sel && a[15:14] == 2'b01;
        chk(data_drive_en == (win && rw), "R3 drive_en", data_drive_en, win && rw);
        chk(sram_we == (win && !rw), "R4 sram_we", sram_we, win && !rw);
        if (win) begin
            chk(sram_addr == {model_bank, a[13:0]}, tag, sram_addr, {model_bank, a[13:0]});
            chk(sram_chip_sel == 4'(1 << model_bank[7:6]), "R2 chip_sel",
                sram_chip_sel, 4'(1 << model_bank[7:6]));
        end else begin
            chk(sram_chip_sel == 4'b0, "R2 chip_sel idle", sram_chip_sel, 0);
        end
        bus_phi2 = 1'b0;
        @(negedge clk);
        model_bank = next_bank(map_mode, model_bank, a, d, rw, sel);
        @(negedge clk);
        bus_rw = 1'b1; card_sel = 1'b0; bus_addr = 16'h0000;
    endtask

    task automatic write_verify(input logic [15:0] a, input logic [7:0] d,
                                input logic sel, input string tag);
        bus_op(a, d, 1'b0, sel, tag);
        bus_op(16'h5123, 8'h00, 1'b1, 1'b1, tag);
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        map_mode = m; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_bank = 8'h00;
        bus_op(16'h4000, 8'h00, 1'b1, 1'b1, "R1 reset bank");
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] seed_v;
        seed_v = $urandom(32'h5EED_0042);
        for (int m = 0; m < 4; m++) begin
            // dirty the bank, then reset must clear it
            map_mode = 2'(m);
            rst_n = 1'b1;
            write_verify(16'hD1FE, 8'h5A, 1'b1, "R5 pre-reset load");
            do_reset(2'(m));

            write_verify(16'hD1FE, 8'hC5, 1'b1, m == 0 ? "R5 native full" : "R6 native fold");
            write_verify(16'hD1FE, 8'hFF, 1'b1, m == 0 ? "R5 native full" : "R6 native fold");
            write_verify(16'hD1FE, 8'h3C, 1'b0, "R9 unselected native");
            bus_op(16'hD1FE, 8'h11, 1'b1, 1'b1, "R9 register read");
            bus_op(16'h6000, 8'h00, 1'b1, 1'b1, "R9 bank after read");
            write_verify(16'hCFFF, 8'hC1, 1'b0, "R7 rom mirror");
            bus_op(16'hCFFF, 8'h00, 1'b1, 1'b1, "R3 mirror read");
            write_verify(16'hD301, 8'h93, 1'b0, "R8 port bits");
            write_verify(16'hD301, 8'h44, 1'b1, "R8 port order");
            write_verify(16'hD301, 8'h6C, 1'b0, "R8 port all ones");
            bus_op(16'hD301, 8'h00, 1'b1, 1'b1, "R3 port read");

            // R10: write strobe during phase 2 high, but bus becomes a read before the fall
            @(negedge clk);
            bus_addr = 16'hD1FE; bus_data = 8'h77; bus_rw = 1'b0; card_sel = 1'b1;
            bus_phi2 = 1'b1;
            repeat (2) @(negedge clk);
            bus_addr = 16'h4001; bus_rw = 1'b1;
            @(negedge clk);
            chk(sram_addr[21:14] == model_bank, "R10 no load before fall",
                sram_addr[21:14], model_bank);
            bus_phi2 = 1'b0;
            repeat (2) @(negedge clk);
            bus_op(16'h4002, 8'h00, 1'b1, 1'b1, "R10 bank after read fall");

            // random traffic
            for (int i = 0; i < 60; i++) begin
                int kind;
                logic [15:0] a;
                logic [7:0]  d;
                logic        rw, sel;
                kind = int'($urandom % 6);
                d    = 8'($urandom);
                rw   = ($urandom % 10) < 3;
                sel  = 1'($urandom);
                case (kind)
                    0: begin a = 16'hD1FE; sel = 1'b1; end
                    1: a = 16'hCFFF;
                    2: a = 16'hD301;
                    3: a = 16'h4000 | 16'($urandom % 16384);
                    4: a = 16'($urandom);
                    default: begin a = 16'hD1FE; sel = 1'b0; end
                endcase
                bus_op(a, d, rw, sel, "R2 random op");
                bus_op(16'h7FFF, 8'h00, 1'b1, 1'b1, "R5 R6 R7 R8 random bank");
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule